// File: doc/BRIEF.md
# Down-Counting Match Timer Bank

This peripheral holds a bank of independent down-counters behind a word-addressed register port. The port has an address, a write strobe, write data and read data. Each counter has four registers: a live count, a reload value and two compare values. The counter decrements on every clock cycle, or only on rising edges of its own external tick pin. A control bit picks which.

Software starts a counter by setting its enable bit. Setting that bit copies the reload value into the count. When the count has reached zero, the next tick restores the reload value, so the counter runs periodically with no software help.

A tick taken while the count equals either compare value sets a sticky flag. There is no mask for these flags. Underflow flags are set only when the counter's interrupt-enable bit is set. Each counter drives one interrupt line.

Control bits are set through one address and cleared selectively through a second address. Flags are cleared by writing ones.

Top module: `down_match_timer`

## Requirements
- R1: Counter n (n = 0, 1, 2) owns four words at byte offsets 16n + 0 (count), 16n + 4 (reload), 16n + 8 (first compare) and 16n + 12 (second compare). Each is written with the full data word and reads back at the same offset. Unused offsets read zero.
- R2: The control word sits at offset 0x30. For counter n, bit 4n is enable, bit 4n+1 selects the external tick (1) or the clock (0), and bit 4n+2 is interrupt enable. All other bits read zero. Writing 0x30 replaces the control word. Writing offset 0x3C clears each control bit whose data bit is 1 and leaves the others alone. Offset 0x3C reads zero.
- R3: An enabled counter that uses the clock decrements by one on every clock edge. A disabled counter holds its count.
- R4: A write that takes a counter's enable bit from 0 to 1 makes the count equal to that counter's reload value at the same edge.
- R5: A tick taken while the count is zero loads the reload value instead of decrementing. A counter reloaded with N therefore underflows every N+1 ticks.
- R6: With the external source selected, the counter decrements once for each low-to-high transition of its tick pin. The input passes through a two-stage synchronizer, so the count changes on the third clock edge that samples the new high level. A level held high gives no further ticks.
- R7: A tick taken while the count equals the first compare value sets status bit 3n. A tick taken while it equals the second compare value sets status bit 3n+1. Neither flag has a mask.
- R8: A tick taken at count zero sets status bit 3n+2 only when the counter's interrupt-enable bit is 1.
- R9: The status word is at offset 0x34. Writing a 1 to a bit clears that flag, and writing a 0 leaves it unchanged. When a new event and a clear hit the same flag in the same cycle, the flag stays set.
- R10: Interrupt line n is high exactly when any of status bits 3n, 3n+1 or 3n+2 is set.
- R11: A write to a count register sets the count to the written value at the next edge and takes priority over a tick in that cycle.
- R12: After reset, every register, the control word and the status word read zero, and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| ext_tick | input | NUM_TIMERS | Per-counter external tick, asynchronous |
| irq | output | NUM_TIMERS | Per-counter interrupt line |

## Verification
The bench builds the block with its defaults: three counters, 32-bit data and an 8-bit address. With three counters, the control and status words land at 0x30 and 0x34 and the clear alias at 0x3C, matching the map in the requirements. The bench keeps reload and compare values small, so the compare hits, the zero-count reload and the periodic underflow all occur within a few dozen cycles. The external-tick path is driven with slow pulses on one counter while another runs from the clock. A sticky clear is aimed at the exact cycle a compare hit arrives, which exercises the case where a new event and a clear land together.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control word: one group of bits per counter.
    localparam int unsigned CTRL_GRP  = 4;
    localparam int unsigned CTRL_EN   = 0;
    localparam int unsigned CTRL_EXT  = 1;
    localparam int unsigned CTRL_IEN  = 2;

    // Status word: one group of flags per counter.
    localparam int unsigned ST_GRP    = 3;
    localparam int unsigned ST_M1     = 0;
    localparam int unsigned ST_M2     = 1;
    localparam int unsigned ST_UNF    = 2;

    // Byte span of one counter's register group.
    localparam int unsigned GRP_BYTES = 16;

    typedef struct packed {
        logic m1;
        logic m2;
        logic unf;
    } tmr_evt_t;

endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [2:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Edge detector: second stage high, third stage low.
    assign rise = s_q.sh[1] & ~s_q.sh[2];

    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [3:0]       wr_sel,   // {cmp2, cmp1, reload, count}
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W-1:0] cmp1_o,
    output logic [CNT_W-1:0] cmp2_o,
    output tmr_evt_t         evt
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cmp1;
        logic [CNT_W-1:0] cmp2;
    } chan_t;

    chan_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        evt = '0;
        if (tick) begin
            evt.m1  = (c_q.count == c_q.cmp1);
            evt.m2  = (c_q.count == c_q.cmp2);
            evt.unf = (c_q.count == '0);
            if (c_q.count == '0) c_d.count = c_q.reload;
            else                 c_d.count = c_q.count - 1'b1;
        end
        if (load_en)   c_d.count  = c_q.reload;
        if (wr_sel[0]) c_d.count  = wr_data;
        if (wr_sel[1]) c_d.reload = wr_data;
        if (wr_sel[2]) c_d.cmp1   = wr_data;
        if (wr_sel[3]) c_d.cmp2   = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count_o  = c_q.count;
    assign reload_o = c_q.reload;
    assign cmp1_o   = c_q.cmp1;
    assign cmp2_o   = c_q.cmp2;

    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_o != '0 && !load_en && !wr_sel[0])
        |=> count_o == $past(count_o) - 1'b1);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en && !wr_sel[0]) |=> $stable(count_o));

    assert_load_on_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !wr_sel[0]) |=> count_o == $past(reload_o));

    assert_reload_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_o == '0 && !load_en && !wr_sel[0])
        |=> count_o == $past(reload_o));

    assert_sw_count_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[0] |=> count_o == $past(wr_data));

endmodule

// File: rtl/down_match_timer.sv
module down_match_timer
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 3,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_TIMERS-1:0] ext_tick,
    output logic [NUM_TIMERS-1:0] irq
);
    localparam int unsigned CTRL_W = CTRL_GRP * NUM_TIMERS;
    localparam int unsigned ST_W   = ST_GRP * NUM_TIMERS;
    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(NUM_TIMERS * GRP_BYTES);
    localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(NUM_TIMERS * GRP_BYTES + 4);
    localparam logic [ADDR_W-1:0] CLR_OFS  = ADDR_W'(NUM_TIMERS * GRP_BYTES + 12);

    function automatic logic [CTRL_W-1:0] f_ctrl_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            m[CTRL_GRP*t + CTRL_EN]  = 1'b1;
            m[CTRL_GRP*t + CTRL_EXT] = 1'b1;
            m[CTRL_GRP*t + CTRL_IEN] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [CTRL_W-1:0] CTRL_MASK = f_ctrl_mask();

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [ST_W-1:0]   status;
    } top_t;

    top_t r_d, r_q;

    logic [NUM_TIMERS-1:0] ext_rise;
    logic [NUM_TIMERS-1:0] tick;
    logic [NUM_TIMERS-1:0] load_en;
    logic [3:0]            wr_sel [NUM_TIMERS];
    logic [DATA_W-1:0]     cnt_a  [NUM_TIMERS];
    logic [DATA_W-1:0]     rld_a  [NUM_TIMERS];
    logic [DATA_W-1:0]     c1_a   [NUM_TIMERS];
    logic [DATA_W-1:0]     c2_a   [NUM_TIMERS];
    tmr_evt_t              evt_a  [NUM_TIMERS];
    logic [ST_W-1:0]       ev_flat;

    logic wr_ctrl, wr_clr, wr_stat;
    assign wr_ctrl = bus_we && (bus_addr == CTRL_OFS);
    assign wr_clr  = bus_we && (bus_addr == CLR_OFS);
    assign wr_stat = bus_we && (bus_addr == STAT_OFS);

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(t * GRP_BYTES);

        tmr_tick_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (ext_tick[t]),
            .rise     (ext_rise[t])
        );

        assign tick[t] = r_q.ctrl[CTRL_GRP*t + CTRL_EN] &&
                         (r_q.ctrl[CTRL_GRP*t + CTRL_EXT] ? ext_rise[t] : 1'b1);
        assign load_en[t] = wr_ctrl && bus_wdata[CTRL_GRP*t + CTRL_EN] &&
                            !r_q.ctrl[CTRL_GRP*t + CTRL_EN];
        assign wr_sel[t] = {bus_we && bus_addr == BASE + ADDR_W'(12),
                            bus_we && bus_addr == BASE + ADDR_W'(8),
                            bus_we && bus_addr == BASE + ADDR_W'(4),
                            bus_we && bus_addr == BASE};

        tmr_channel #(.CNT_W(DATA_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick[t]),
            .load_en  (load_en[t]),
            .wr_sel   (wr_sel[t]),
            .wr_data  (bus_wdata),
            .count_o  (cnt_a[t]),
            .reload_o (rld_a[t]),
            .cmp1_o   (c1_a[t]),
            .cmp2_o   (c2_a[t]),
            .evt      (evt_a[t])
        );

        assign ev_flat[ST_GRP*t + ST_M1]  = evt_a[t].m1;
        assign ev_flat[ST_GRP*t + ST_M2]  = evt_a[t].m2;
        assign ev_flat[ST_GRP*t + ST_UNF] = evt_a[t].unf &&
                                           r_q.ctrl[CTRL_GRP*t + CTRL_IEN];

        assign irq[t] = |r_q.status[ST_GRP*t +: ST_GRP];

        assert_unf_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(r_q.status[ST_GRP*t + ST_UNF]) |-> $past(r_q.ctrl[CTRL_GRP*t + CTRL_IEN]));
    end

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) r_d.ctrl = bus_wdata[CTRL_W-1:0] & CTRL_MASK;
        if (wr_clr)  r_d.ctrl = r_q.ctrl & ~bus_wdata[CTRL_W-1:0];
        r_d.status = (r_q.status & ~(wr_stat ? bus_wdata[ST_W-1:0] : '0)) | ev_flat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (bus_addr == ADDR_W'(t * GRP_BYTES))      bus_rdata = cnt_a[t];
            if (bus_addr == ADDR_W'(t * GRP_BYTES + 4))  bus_rdata = rld_a[t];
            if (bus_addr == ADDR_W'(t * GRP_BYTES + 8))  bus_rdata = c1_a[t];
            if (bus_addr == ADDR_W'(t * GRP_BYTES + 12)) bus_rdata = c2_a[t];
        end
        if (bus_addr == CTRL_OFS) bus_rdata = DATA_W'(r_q.ctrl);
        if (bus_addr == STAT_OFS) bus_rdata = DATA_W'(r_q.status);
    end

    assert_event_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_flat) |=> ((r_q.status & $past(ev_flat)) == $past(ev_flat)));

    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((r_q.status & $past(bus_wdata[ST_W-1:0]) & ~$past(ev_flat)) == '0));

    assert_alias_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((r_q.ctrl & $past(bus_wdata[CTRL_W-1:0])) == '0));

endmodule

// File: tb/test_down_match_timer.sv
module test_down_match_timer;
    localparam int NT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NT-1:0] ext = '0;
    logic [NT-1:0] irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    down_match_timer i_down_match_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .ext_tick(ext), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] m_cnt [NT];
    logic [31:0] m_rld [NT];
    logic [31:0] m_c1  [NT];
    logic [31:0] m_c2  [NT];
    logic [2:0]  m_sh  [NT];
    logic [31:0] m_ctrl, m_st;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                m_cnt[t] = 0; m_rld[t] = 0; m_c1[t] = 0; m_c2[t] = 0; m_sh[t] = 0;
            end
            m_ctrl = 0; m_st = 0;
        end else begin
            logic [31:0] ev, nctrl;
            ev = 0;
            nctrl = m_ctrl;
            if (we && addr == 8'h30) nctrl = wdata & 32'h777;
            if (we && addr == 8'h3C) nctrl = m_ctrl & ~wdata;
            for (int t = 0; t < NT; t++) begin
                bit en, xs, ien, rise, tk, ld;
                logic [31:0] nc;
                en   = m_ctrl[4*t];
                xs   = m_ctrl[4*t+1];
                ien  = m_ctrl[4*t+2];
                rise = m_sh[t][1] & ~m_sh[t][2];
                m_sh[t] = {m_sh[t][1:0], ext[t]};
                tk = en && (xs ? rise : 1'b1);
                ld = we && addr == 8'h30 && wdata[4*t] && !en;
                nc = m_cnt[t];
                if (tk) begin
                    if (m_cnt[t] == m_c1[t]) ev[3*t] = 1;
                    if (m_cnt[t] == m_c2[t]) ev[3*t+1] = 1;
                    if (m_cnt[t] == 0) begin
                        if (ien) ev[3*t+2] = 1;
                        nc = m_rld[t];
                    end else nc = m_cnt[t] - 1;
                end
                if (ld) nc = m_rld[t];
                if (we && addr == 8'(16*t)) nc = wdata;
                m_cnt[t] = nc;
                if (we && addr == 8'(16*t+4))  m_rld[t] = wdata;
                if (we && addr == 8'(16*t+8))  m_c1[t]  = wdata;
                if (we && addr == 8'(16*t+12)) m_c2[t]  = wdata;
            end
            m_ctrl = nctrl;
            m_st = (m_st & ~((we && addr == 8'h34) ? wdata : 32'h0)) | ev;
        end
    end

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        if (a < 8'(16*NT) && a[1:0] == 2'b00) begin
            case (a[3:2])
                2'd0: return m_cnt[a/16];
                2'd1: return m_rld[a/16];
                2'd2: return m_c1[a/16];
                default: return m_c2[a/16];
            endcase
        end
        if (a == 8'h30) return m_ctrl;
        if (a == 8'h34) return m_st;
        return 0;
    endfunction

    // Per-cycle comparison against the model (R1 readback, R10 interrupt lines)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NT-1:0] mi;
            for (int t = 0; t < NT; t++) mi[t] = |m_st[3*t +: 3];
            n_cmp++;
            if (rdata !== model_rd(addr)) begin
                n_bad++;
                $display("FAIL R1 readback @%h: actual %h expected %h", addr, rdata, model_rd(addr));
            end
            n_cmp++;
            if (irq !== mi) begin
                n_bad++;
                $display("FAIL R10 irq: actual %b expected %b", irq, mi);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #2;
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    task automatic pulse(input int t);
        ext[t] = 1'b1;
        repeat (4) @(posedge clk);
        #2 ext[t] = 1'b0;
        repeat (4) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] a0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R12: reset state
        rd_chk(8'h30, 0, "R12 control");
        rd_chk(8'h34, 0, "R12 status");
        rd_chk(8'h14, 0, "R12 reload");
        chk("R12 irq", 32'(irq), 0);

        // R1, R3, R4, R5, R7, R8, R9 on counter 0
        wr(8'h04, 10); wr(8'h08, 7); wr(8'h0C, 2);
        rd_chk(8'h04, 10, "R1 reload");
        rd_chk(8'h08, 7, "R1 cmp1");
        rd_chk(8'h0C, 2, "R1 cmp2");
        rd_chk(8'h40, 0, "R1 unused");
        wr(8'h30, 32'h1);
        rd_chk(8'h00, 10, "R4 load on enable");
        repeat (3) @(posedge clk); #2;
        rd_chk(8'h00, 7, "R3 decrement");
        @(posedge clk); #2;
        rd_chk(8'h34, 32'h1, "R7 cmp1 flag");
        chk("R10 irq0", 32'(irq), 1);
        repeat (5) @(posedge clk); #2;
        rd_chk(8'h34, 32'h3, "R7 cmp2 flag");
        repeat (2) @(posedge clk); #2;
        rd_chk(8'h00, 10, "R5 reload at zero");
        rd_chk(8'h34, 32'h3, "R8 underflow flag gated off");
        wr(8'h34, 32'h1);
        rd_chk(8'h34, 32'h2, "R9 write-one clear");
        wr(8'h34, 32'h1);
        rd_chk(8'h34, 32'h3, "R9 event wins over clear");
        wr(8'h3C, 32'h1);
        rd_chk(8'h30, 0, "R2 clear alias");
        rd_chk(8'h3C, 0, "R2 alias reads zero");
        rd_chk(8'h00, 4, "R3 stop value");
        a0 = rdata;
        repeat (3) @(posedge clk); #2;
        rd_chk(8'h00, a0, "R3 disabled holds");

        // R5, R8, R10 periodic underflow on counter 1
        wr(8'h34, 32'h1FF);
        rd_chk(8'h34, 0, "R9 clear all");
        chk("R10 irq low", 32'(irq), 0);
        wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF); wr(8'h14, 3);
        wr(8'h30, 32'h50);
        repeat (4) @(posedge clk); #2;
        rd_chk(8'h10, 3, "R5 periodic reload");
        rd_chk(8'h34, 32'h20, "R8 underflow flag");
        chk("R10 irq1", 32'(irq), 32'h2);

        // R6, R11, R7 on counter 2 with external ticks
        wr(8'h28, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF); wr(8'h24, 100);
        wr(8'h30, 32'h350);
        repeat (5) @(posedge clk); #2;
        rd_chk(8'h20, 100, "R6 no edge no tick");
        pulse(2);
        rd_chk(8'h20, 99, "R6 one edge");
        pulse(2); pulse(2);
        rd_chk(8'h20, 97, "R6 three edges");
        wr(8'h20, 50);
        rd_chk(8'h20, 50, "R11 count write");
        wr(8'h28, 50);
        pulse(2);
        rd_chk(8'h20, 49, "R6 tick after write");
        addr = 8'h34; #1;
        chk("R7 cmp1 flag counter2", rdata & 32'h1C0, 32'h040);

        // R2 set and selective clear
        wr(8'h30, 32'hFFFF_FFFF);
        rd_chk(8'h30, 32'h777, "R2 writable bits");
        wr(8'h3C, 32'h0000_0222);
        rd_chk(8'h30, 32'h555, "R2 selective clear");
        wr(8'h3C, 32'hFFFF_FFFF);
        rd_chk(8'h30, 0, "R2 clear all");
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule